// File: doc/BRIEF.md
# Status Register and Branch Evaluator

This block keeps the processor status word of a 64-bit core and answers, for a conditional branch, whether the branch is taken. The sequencer gives it a decoded flag-operation code, an ALU flag update tagged with the class of instruction that produced it, and a full-word load used when the status word comes back from the stack. The current word is always visible on a read port, which the push path stores to the stack. A branch-condition selector picks one flag test and the block returns a combinational taken signal.

Six flags live in the low byte: carry, zero, interrupt-disable, stack-protection, overflow and negative. The remaining upper bits are storage only. The interrupt-disable flag is brought out as a mask for the interrupt logic. When several updates land in one cycle, a fixed priority decides: the full-word load wins over everything, the whole-word clear wins over flag edits, and a single-flag set or clear wins over the ALU update on its own bit.

Top module: `status_flags`

## Requirements
- R1: After reset the status word reads 64'h4 (only the interrupt-disable bit, bit 2, is set).
- R2: flagOp code 1 zeroes all 64 bits in one cycle, even when an ALU update arrives in the same cycle.
- R3: flagOp codes set or clear one flag and leave all other bits unchanged: 2/3 set/clear carry (bit 0), 4/5 set/clear interrupt-disable (bit 2), 6/7 set/clear stack-protection (bit 3), 8/9 set/clear overflow (bit 6); code 0 and codes 10 to 15 do nothing.
- R4: irqMask equals the interrupt-disable bit (bit 2) of the status word.
- R5: With aluEn high, aluFlags ({N,V,Z,C}) are written only to the flags of aluClass: 0 writes N and Z (loads, transfers, logic), 1 writes N, Z and C (shifts, rotates), 2 writes N, V, Z and C (add, subtract, compare, multiply), 3 writes N, V and Z (divide); N is bit 7, Z bit 1.
- R6: With pullEn high, the whole word is replaced by pullData on the next clock edge.
- R7: statusOut presents the full current status word at every cycle.
- R8: brTaken follows brCond: 0 when N=0, 1 when N=1, 2 when C=1, 3 when C=0, 4 when Z=1, 5 when Z=0, 6 when V=1, 7 when V=0.
- R9: A full-word load in the same cycle as any flag operation or ALU update takes priority; the result equals pullData.
- R10: A single-flag set or clear in the same cycle as an ALU update overrides the ALU value on that flag only; the ALU still writes its other flags.
- R11: Bits 8 to 63 change only on a full-word load or a whole-word clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flagOp | input | 4 | Decoded flag operation code |
| aluEn | input | 1 | ALU flag update valid |
| aluClass | input | 2 | Instruction class selecting which flags the ALU writes |
| aluFlags | input | 4 | ALU result flags {N,V,Z,C} |
| pullEn | input | 1 | Load the whole word from pullData |
| pullData | input | 64 | Status word taken from the stack |
| brCond | input | 3 | Branch condition selector |
| statusOut | output | 64 | Current status word (push read port) |
| brTaken | output | 1 | Selected branch condition holds |
| irqMask | output | 1 | Maskable interrupts blocked |

## Verification
Two pairings can meet in a single cycle: a stack pull against a flag operation or ALU update, and a single-flag edit against an ALU update. The table drives each pairing in one vector, for example a pull of 64'h10 together with set-overflow, and the clear-carry code together with an all-ones arithmetic update, and judges the word read one clock later against the value the priority rules give. A whole-word clear paired with an ALU update covers the third priority level.

// File: rtl/statflag_pkg.sv
package statflag_pkg;
  localparam int FLAG_W = 8;
  localparam int BIT_C  = 0;
  localparam int BIT_Z  = 1;
  localparam int BIT_I  = 2;
  localparam int BIT_S  = 3;
  localparam int BIT_V  = 6;
  localparam int BIT_N  = 7;

  typedef enum logic [3:0] {
    FOP_NONE    = 4'd0,
    FOP_CLR_ALL = 4'd1,
    FOP_SET_C   = 4'd2,
    FOP_CLR_C   = 4'd3,
    FOP_SET_I   = 4'd4,
    FOP_CLR_I   = 4'd5,
    FOP_SET_S   = 4'd6,
    FOP_CLR_S   = 4'd7,
    FOP_SET_V   = 4'd8,
    FOP_CLR_V   = 4'd9
  } flag_op_e;

  typedef enum logic [1:0] {
    ALU_NZ   = 2'd0,
    ALU_NZC  = 2'd1,
    ALU_NVZC = 2'd2,
    ALU_NVZ  = 2'd3
  } alu_cls_e;

  typedef enum logic [2:0] {
    BR_POS = 3'd0,
    BR_NEG = 3'd1,
    BR_CS  = 3'd2,
    BR_CC  = 3'd3,
    BR_EQ  = 3'd4,
    BR_NE  = 3'd5,
    BR_VS  = 3'd6,
    BR_VC  = 3'd7
  } br_cond_e;

  typedef struct packed {
    logic              load;
    logic              clearAll;
    logic [FLAG_W-1:0] setMask;
    logic [FLAG_W-1:0] clrMask;
    logic [FLAG_W-1:0] aluMask;
  } stat_strobe_t;
endpackage

// File: rtl/status_ctrl.sv
module status_ctrl
  import statflag_pkg::*;
(
  input  logic [3:0]   flagOp,
  input  logic         aluEn,
  input  logic [1:0]   aluClass,
  input  logic         pullEn,
  output stat_strobe_t strobe
);
  localparam logic [FLAG_W-1:0] ONE = FLAG_W'(1);

  logic [FLAG_W-1:0] classMask;

  always_comb begin
    case (aluClass)
      ALU_NZ:   classMask = (ONE << BIT_N) | (ONE << BIT_Z);
      ALU_NZC:  classMask = (ONE << BIT_N) | (ONE << BIT_Z) | (ONE << BIT_C);
      ALU_NVZC: classMask = (ONE << BIT_N) | (ONE << BIT_V) | (ONE << BIT_Z) | (ONE << BIT_C);
      default:  classMask = (ONE << BIT_N) | (ONE << BIT_V) | (ONE << BIT_Z);
    endcase
  end

  always_comb begin
    strobe          = '0;
    strobe.load     = pullEn;
    strobe.aluMask  = aluEn ? classMask : '0;
    case (flagOp)
      FOP_CLR_ALL: strobe.clearAll = 1'b1;
      FOP_SET_C:   strobe.setMask  = ONE << BIT_C;
      FOP_CLR_C:   strobe.clrMask  = ONE << BIT_C;
      FOP_SET_I:   strobe.setMask  = ONE << BIT_I;
      FOP_CLR_I:   strobe.clrMask  = ONE << BIT_I;
      FOP_SET_S:   strobe.setMask  = ONE << BIT_S;
      FOP_CLR_S:   strobe.clrMask  = ONE << BIT_S;
      FOP_SET_V:   strobe.setMask  = ONE << BIT_V;
      FOP_CLR_V:   strobe.clrMask  = ONE << BIT_V;
      default:     ;
    endcase
  end
endmodule

// File: rtl/status_branch.sv
module status_branch
  import statflag_pkg::*;
(
  input  logic [FLAG_W-1:0] flagByte,
  input  logic [2:0]        brCond,
  output logic              brTaken
);
  logic testBit;

  always_comb begin
    case (brCond[2:1])
      2'd0:    testBit = flagByte[BIT_N];
      2'd1:    testBit = flagByte[BIT_C];
      2'd2:    testBit = flagByte[BIT_Z];
      default: testBit = flagByte[BIT_V];
    endcase
  end

  // Positive, carry-clear, not-equal and overflow-clear test for zero;
  // their odd/even position alternates, so the polarity is decoded per code.
  always_comb begin
    case (brCond)
      BR_POS, BR_CC, BR_NE, BR_VC: brTaken = ~testBit;
      default:                     brTaken = testBit;
    endcase
  end
endmodule

// File: rtl/status_data.sv
module status_data
  import statflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  stat_strobe_t      strobe,
  input  logic [DATA_W-1:0] pullData,
  input  logic [3:0]        aluFlags,
  output logic [DATA_W-1:0] statusQ,
  output logic              irqMask
);
  localparam logic [DATA_W-1:0] RESET_VAL = DATA_W'(1) << BIT_I;

  logic [FLAG_W-1:0] aluVec;
  logic [FLAG_W-1:0] lowMerged;
  logic [FLAG_W-1:0] lowNext;
  logic [DATA_W-1:0] nextQ;

  always_comb begin
    aluVec        = '0;
    aluVec[BIT_N] = aluFlags[3];
    aluVec[BIT_V] = aluFlags[2];
    aluVec[BIT_Z] = aluFlags[1];
    aluVec[BIT_C] = aluFlags[0];
  end

  assign lowMerged = (statusQ[FLAG_W-1:0] & ~strobe.aluMask) | (aluVec & strobe.aluMask);
  assign lowNext   = (lowMerged & ~strobe.clrMask) | strobe.setMask;

  always_comb begin
    if (strobe.load)          nextQ = pullData;
    else if (strobe.clearAll) nextQ = '0;
    else                      nextQ = {statusQ[DATA_W-1:FLAG_W], lowNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= RESET_VAL;
    else       statusQ <= nextQ;
  end

  assign irqMask = statusQ[BIT_I];

  // R6 R9
  pull_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> statusQ == $past(pullData));

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearAll && !strobe.load) |=> statusQ == '0);

  // R11
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.clearAll) |=>
      statusQ[DATA_W-1:FLAG_W] == $past(statusQ[DATA_W-1:FLAG_W]));

  // R3
  set_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.clearAll && strobe.setMask != '0) |=>
      (statusQ[FLAG_W-1:0] & $past(strobe.setMask)) == $past(strobe.setMask));

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqMask) |-> $past(strobe.load || strobe.setMask[BIT_I]));
endmodule

// File: rtl/status_flags.sv
module status_flags
  import statflag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        flagOp,
  input  logic              aluEn,
  input  logic [1:0]        aluClass,
  input  logic [3:0]        aluFlags,
  input  logic              pullEn,
  input  logic [DATA_W-1:0] pullData,
  input  logic [2:0]        brCond,
  output logic [DATA_W-1:0] statusOut,
  output logic              brTaken,
  output logic              irqMask
);
  stat_strobe_t strobe;

  status_ctrl u_ctrl (
    .flagOp   (flagOp),
    .aluEn    (aluEn),
    .aluClass (aluClass),
    .pullEn   (pullEn),
    .strobe   (strobe)
  );

  status_data #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pullData (pullData),
    .aluFlags (aluFlags),
    .statusQ  (statusOut),
    .irqMask  (irqMask)
  );

  status_branch u_branch (
    .flagByte (statusOut[FLAG_W-1:0]),
    .brCond   (brCond),
    .brTaken  (brTaken)
  );
endmodule

// File: tb/status_flags_bench.sv
module status_flags_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic [3:0]  flagOp;
  logic        aluEn;
  logic [1:0]  aluClass;
  logic [3:0]  aluFlags;
  logic        pullEn;
  logic [63:0] pullData;
  logic [2:0]  brCond;
  logic [63:0] statusOut;
  logic        brTaken;
  logic        irqMask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  status_flags u_status_flags (
    .clk(clk), .rstN(rstN), .flagOp(flagOp), .aluEn(aluEn), .aluClass(aluClass),
    .aluFlags(aluFlags), .pullEn(pullEn), .pullData(pullData), .brCond(brCond),
    .statusOut(statusOut), .brTaken(brTaken), .irqMask(irqMask)
  );

  typedef struct packed {
    logic [3:0]  reqId;
    logic [3:0]  fop;
    logic        alu;
    logic [1:0]  cls;
    logic [3:0]  flg;
    logic        pull;
    logic [63:0] pd;
    logic [63:0] exp;
  } vec_t;

  localparam int NVEC = 18;
  // Cumulative: each expected word follows from the one above. R7 read port.
  localparam vec_t VECS [NVEC] = '{
    '{4'd3, 4'd2, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'h5},   // R3 set C
    '{4'd3, 4'd6, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'hD},   // R3 set S
    '{4'd3, 4'd8, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'h4D},  // R3 set V
    '{4'd3, 4'd5, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'h49},  // R3 clear I
    '{4'd5, 4'd0, 1'b1, 2'd0, 4'hF, 1'b0, 64'h0, 64'hCB},  // R5 NZ class
    '{4'd5, 4'd0, 1'b1, 2'd0, 4'h0, 1'b0, 64'h0, 64'h49},  // R5 NZ class
    '{4'd5, 4'd0, 1'b1, 2'd1, 4'h4, 1'b0, 64'h0, 64'h48},  // R5 NZC class
    '{4'd5, 4'd0, 1'b1, 2'd2, 4'hB, 1'b0, 64'h0, 64'h8B},  // R5 NVZC class
    '{4'd5, 4'd0, 1'b1, 2'd3, 4'h5, 1'b0, 64'h0, 64'h49},  // R5 NVZ class
    '{4'd6, 4'd0, 1'b0, 2'd0, 4'h0, 1'b1, 64'hA5A5_0000_1234_5678, 64'hA5A5_0000_1234_5678}, // R6
    '{4'd2, 4'd1, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'h0},   // R2
    '{4'd3, 4'd12,1'b0, 2'd0, 4'h0, 1'b0, 64'h0, 64'h0},   // R3 unused code
    '{4'd6, 4'd0, 1'b0, 2'd0, 4'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FF00}, // R6
    '{4'd11,4'd0, 1'b1, 2'd2, 4'hF, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFC3}, // R11
    '{4'd10,4'd3, 1'b1, 2'd2, 4'hF, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFC2}, // R10
    '{4'd9, 4'd8, 1'b0, 2'd0, 4'h0, 1'b1, 64'h10, 64'h10}, // R9 pull vs set V
    '{4'd2, 4'd1, 1'b1, 2'd0, 4'hF, 1'b0, 64'h0, 64'h0},   // R2 clear vs ALU
    '{4'd9, 4'd9, 1'b1, 2'd2, 4'hF, 1'b1, 64'h3, 64'h3}    // R9 pull vs all
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    flagOp = 4'd0; aluEn = 1'b0; aluClass = 2'd0; aluFlags = 4'h0;
    pullEn = 1'b0; pullData = '0;
  endtask

  task automatic step(input logic [3:0] fop, input logic alu, input logic [1:0] cls,
                      input logic [3:0] flg, input logic pull, input logic [63:0] pd);
    flagOp = fop; aluEn = alu; aluClass = cls; aluFlags = flg; pullEn = pull; pullData = pd;
    @(negedge clk);
    idle();
  endtask

  function automatic logic expTaken(input logic [7:0] f, input logic [2:0] c);
    case (c)
      3'd0: return !f[7];
      3'd1: return  f[7];
      3'd2: return  f[0];
      3'd3: return !f[0];
      3'd4: return  f[1];
      3'd5: return !f[1];
      3'd6: return  f[6];
      default: return !f[6];
    endcase
  endfunction

  task automatic branchSweep(input logic [7:0] pattern);
    step(4'd0, 1'b0, 2'd0, 4'h0, 1'b1, {56'h0, pattern});
    for (int c = 0; c < 8; c++) begin
      brCond = c[2:0];
      #1;
      chk($sformatf("R8 cond=%0d word=%h", c, pattern), {63'h0, brTaken},
          {63'h0, expTaken(pattern, c[2:0])});
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; brCond = 3'd0;
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset word", statusOut, 64'h4);
    chk("R4 mask after reset", {63'h0, irqMask}, 64'h1);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].fop, VECS[i].alu, VECS[i].cls, VECS[i].flg, VECS[i].pull, VECS[i].pd);
      chk($sformatf("R%0d vector %0d", VECS[i].reqId, i), statusOut, VECS[i].exp);
    end

    // R4 mask tracks interrupt-disable set and clear
    step(4'd4, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0);
    chk("R4 mask after set I", {63'h0, irqMask}, 64'h1);
    chk("R3 set I word", statusOut, 64'h7);
    step(4'd5, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0);
    chk("R4 mask after clear I", {63'h0, irqMask}, 64'h0);

    // R7 idle cycles leave the read port stable; R3 code 15 does nothing
    step(4'd15, 1'b0, 2'd0, 4'h0, 1'b0, 64'h0);
    chk("R7 R3 idle hold", statusOut, 64'h3);

    // R8 all conditions on two complementary flag patterns
    branchSweep(8'h82);
    branchSweep(8'h41);

    // R1 reset mid-run returns to the reset word
    step(4'd0, 1'b0, 2'd0, 4'h0, 1'b1, 64'hDEAD_BEEF_0000_00FF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 reset mid-run", statusOut, 64'h4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule